// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block is the multi-cycle controller that a 16-bit-bus processor core uses to enter and leave exception handlers. It holds the program counter, the status word and the supervisor stack pointer. When a requester presents a vector number and a severity group, the sequencer keeps a copy of the status word and switches the live copy to supervisor mode with tracing off. It then reads the handler address from the vector table in low memory and pushes a stack frame one word at a time. Last, it loads the program counter with the handler address.

A return command reverses the normal frame. It pops the status word and the program counter and moves the stack pointer back up. After a reset the block runs its own load sequence: it sets the status word to its reset value and fetches the stack pointer and program counter from the first two long words of memory.

All memory traffic goes through one word-wide port with a request/ready handshake, and only one access is outstanding at any time. The core writes the program counter and the status word through a small update port while the sequencer is idle.

Top module: `exc_seq_top`

## Requirements
- R1: While `rst` is high the status word reads 0x2700. After `rst` falls the block is busy and performs four reads at byte addresses 0, 2, 4 and 6. The first two words become the stack pointer (high word first) and the last two become the program counter (high word first). `done` then pulses.
- R2: Accepting an exception sets status bit 13 (supervisor) to 1 and clears bit 15 (trace) to 0, leaving the other bits as they were. The status word placed on the stack is the value from before that change.
- R3: The handler address is read as two words, the high word at byte address vector×4 and the low word at vector×4+2. These are the first two accesses of an entry, and at the `done` pulse the program counter equals that address.
- R4: For groups other than 0 (`exc_grp` != 0) the frame is three words below the old stack pointer S: PC high at S-4, PC low at S-2 and the saved status word at S-6. The stack pointer ends at S-6.
- R5: For group 0 (`exc_grp` == 0) the frame is seven words. The access-info word is at S-14, fault address high at S-12, fault address low at S-10, the instruction word at S-8, the status word at S-6, PC high at S-4 and PC low at S-2. The stack pointer ends at S-14.
- R6: A return with status bit 13 set reads the status word at the stack pointer P, PC high at P+2 and PC low at P+4, in that order. These values become the status word and the program counter, and the stack pointer ends at P+6.
- R7: A return request while status bit 13 is 0 raises `priv_err` for exactly one cycle. It makes no memory access and leaves the program counter, status word and stack pointer unchanged.
- R8: Once `mem_req` is high it stays high, with address, write enable and write data unchanged, until a cycle in which `mem_rdy` is high. The sequence does not advance without that handshake.
- R9: `busy` is high from the cycle after a request is accepted until `done`. `done` is a one-cycle pulse in the cycle the new program counter is visible, and `busy` is low in that cycle.
- R10: Raising `rst` in the middle of a sequence abandons it. After release, the reset load of R1 runs from address 0.
- R11: When `exc_req` and `ret_req` arrive in the same idle cycle, the exception entry runs and the return is dropped.
- R12: `upd_en` loads `upd_pc` and `upd_sr` only while the block is idle. While the block is busy the update is ignored, so the program counter still ends at the handler address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the reset load sequence on release |
| exc_req | input | 1 | Exception request, accepted when idle |
| exc_grp | input | 2 | Severity group of the request; 0 selects the seven-word frame |
| exc_vec | input | 8 | Vector number |
| exc_fault_addr | input | 32 | Faulting access address, stored only in a group 0 frame |
| exc_fault_info | input | 16 | Access-type word, stored only in a group 0 frame |
| exc_ir | input | 16 | Instruction word, stored only in a group 0 frame |
| ret_req | input | 1 | Return-from-exception command |
| upd_en | input | 1 | Core write of program counter and status word while idle |
| upd_pc | input | 32 | Program counter value for the update |
| upd_sr | input | 16 | Status word value for the update |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid when `mem_rdy` is high |
| mem_rdy | input | 1 | Access completes in a cycle with `mem_req` and `mem_rdy` high |
| pc_o | output | 32 | Program counter |
| sr_o | output | 16 | Status word |
| ssp_o | output | 32 | Supervisor stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the program counter has been loaded |
| priv_err | output | 1 | One-cycle pulse for a return attempted outside supervisor mode |

## Verification
The bench builds the block with ADDR_W = 12, which gives a 4 KB memory model. That space holds the whole 1 KB vector table and a stack starting at 0xE00. It sweeps all 256 vector numbers, cycling the group through 0, 1 and 2 and the memory wait from zero to three cycles. Every table entry, every frame shape and every handshake stall length is therefore exercised. Each non-severe entry is followed by a return, so that each frame is popped back against the values pushed. Separate runs cover the illegal return, simultaneous requests and a reset in the middle of an entry.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_RV_SSPH, ST_RV_SSPL, ST_RV_PCH, ST_RV_PCL,
    ST_VEC_H, ST_VEC_L,
    ST_PSH_PCL, ST_PSH_PCH, ST_PSH_SR,
    ST_PSH_IR, ST_PSH_ALO, ST_PSH_AHI, ST_PSH_INFO,
    ST_LOAD_PC,
    ST_POP_SR, ST_POP_PCH, ST_POP_PCL
  } step_e;

  function automatic logic step_is_mem(step_e s);
    return !(s == ST_IDLE || s == ST_LOAD_PC);
  endfunction

  function automatic logic step_is_push(step_e s);
    return (s == ST_PSH_PCL) || (s == ST_PSH_PCH) || (s == ST_PSH_SR) ||
           (s == ST_PSH_IR)  || (s == ST_PSH_ALO) || (s == ST_PSH_AHI) ||
           (s == ST_PSH_INFO);
  endfunction

  function automatic logic step_is_pop(step_e s);
    return (s == ST_POP_SR) || (s == ST_POP_PCH) || (s == ST_POP_PCL);
  endfunction

endpackage

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
  import exc_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  exc_req,
  input  logic  exc_sev,
  input  logic  ret_req,
  input  logic  s_bit,
  input  logic  acc,
  output step_e step,
  output logic  start_exc,
  output logic  busy,
  output logic  done,
  output logic  priv_err
);

  step_e state_q, state_d;
  logic  sev_q;
  logic  idle;

  assign idle      = (state_q == ST_IDLE);
  assign start_exc = idle && exc_req;
  assign step      = state_q;
  assign busy      = !idle;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (exc_req)               state_d = ST_VEC_H;
        else if (ret_req && s_bit) state_d = ST_POP_SR;
      end
      ST_RV_SSPH:  if (acc) state_d = ST_RV_SSPL;
      ST_RV_SSPL:  if (acc) state_d = ST_RV_PCH;
      ST_RV_PCH:   if (acc) state_d = ST_RV_PCL;
      ST_RV_PCL:   if (acc) state_d = ST_IDLE;
      ST_VEC_H:    if (acc) state_d = ST_VEC_L;
      ST_VEC_L:    if (acc) state_d = ST_PSH_PCL;
      ST_PSH_PCL:  if (acc) state_d = ST_PSH_PCH;
      ST_PSH_PCH:  if (acc) state_d = ST_PSH_SR;
      ST_PSH_SR:   if (acc) state_d = sev_q ? ST_PSH_IR : ST_LOAD_PC;
      ST_PSH_IR:   if (acc) state_d = ST_PSH_ALO;
      ST_PSH_ALO:  if (acc) state_d = ST_PSH_AHI;
      ST_PSH_AHI:  if (acc) state_d = ST_PSH_INFO;
      ST_PSH_INFO: if (acc) state_d = ST_LOAD_PC;
      ST_LOAD_PC:  state_d = ST_IDLE;
      ST_POP_SR:   if (acc) state_d = ST_POP_PCH;
      ST_POP_PCH:  if (acc) state_d = ST_POP_PCL;
      ST_POP_PCL:  if (acc) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_RV_SSPH;
      sev_q    <= 1'b0;
      done     <= 1'b0;
      priv_err <= 1'b0;
    end else begin
      state_q  <= state_d;
      if (start_exc) sev_q <= exc_sev;
      done     <= (state_q == ST_LOAD_PC) ||
                  (acc && (state_q == ST_RV_PCL || state_q == ST_POP_PCL));
      priv_err <= idle && !exc_req && ret_req && !s_bit;
    end
  end

  assert_reset_load_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> state_q == ST_RV_SSPH);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_exc_first_R11: assert property (@(posedge clk) disable iff (rst)
    (idle && exc_req) |=> state_q == ST_VEC_H);

endmodule

// File: rtl/exc_seq_dp.sv
module exc_seq_dp
  import exc_seq_pkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int          ADDR_W   = 24,
  parameter int          VEC_W    = 8,
  parameter int          S_BIT    = 13,
  parameter int          T_BIT    = 15,
  parameter logic [15:0] RESET_SR = 16'h2700
) (
  input  logic                clk,
  input  logic                rst,
  input  step_e               step,
  input  logic                acc,
  input  logic                start_exc,
  input  logic [VEC_W-1:0]    exc_vec,
  input  logic [2*DATA_W-1:0] exc_fault_addr,
  input  logic [DATA_W-1:0]   exc_fault_info,
  input  logic [DATA_W-1:0]   exc_ir,
  input  logic                upd_en,
  input  logic [2*DATA_W-1:0] upd_pc,
  input  logic [DATA_W-1:0]   upd_sr,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [ADDR_W-1:0]   addr_c,
  output logic                we_c,
  output logic [DATA_W-1:0]   wdata_c,
  output logic [2*DATA_W-1:0] pc_q,
  output logic [DATA_W-1:0]   sr_q,
  output logic [2*DATA_W-1:0] ssp_q
);

  localparam int                LW     = 2 * DATA_W;
  localparam int                WB     = DATA_W / 8;
  localparam logic [ADDR_W-1:0] WB_A   = ADDR_W'(WB);
  localparam logic [LW-1:0]     WB_L   = LW'(WB);
  localparam int                VSHIFT = $clog2(2 * WB);

  logic [DATA_W-1:0] tmp_sr_q;
  logic [LW-1:0]     hnd_q;
  logic [LW-1:0]     fa_q;
  logic [DATA_W-1:0] info_q;
  logic [DATA_W-1:0] ir_q;
  logic [VEC_W-1:0]  vec_q;
  logic [ADDR_W-1:0] vec_base;

  assign vec_base = ADDR_W'(vec_q) << VSHIFT;

  always_comb begin
    addr_c  = '0;
    we_c    = step_is_push(step);
    wdata_c = '0;
    unique case (step)
      ST_RV_SSPH:  addr_c = '0;
      ST_RV_SSPL:  addr_c = WB_A;
      ST_RV_PCH:   addr_c = WB_A * 2;
      ST_RV_PCL:   addr_c = WB_A * 3;
      ST_VEC_H:    addr_c = vec_base;
      ST_VEC_L:    addr_c = vec_base + WB_A;
      ST_POP_SR, ST_POP_PCH, ST_POP_PCL:
                   addr_c = ADDR_W'(ssp_q);
      default:     addr_c = ADDR_W'(ssp_q) - WB_A;
    endcase
    unique case (step)
      ST_PSH_PCL:  wdata_c = pc_q[DATA_W-1:0];
      ST_PSH_PCH:  wdata_c = pc_q[LW-1:DATA_W];
      ST_PSH_SR:   wdata_c = tmp_sr_q;
      ST_PSH_IR:   wdata_c = ir_q;
      ST_PSH_ALO:  wdata_c = fa_q[DATA_W-1:0];
      ST_PSH_AHI:  wdata_c = fa_q[LW-1:DATA_W];
      ST_PSH_INFO: wdata_c = info_q;
      default:     wdata_c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      sr_q     <= RESET_SR;
      ssp_q    <= '0;
      tmp_sr_q <= '0;
      hnd_q    <= '0;
      fa_q     <= '0;
      info_q   <= '0;
      ir_q     <= '0;
      vec_q    <= '0;
    end else begin
      if (start_exc) begin
        tmp_sr_q    <= sr_q;
        sr_q[S_BIT] <= 1'b1;
        sr_q[T_BIT] <= 1'b0;
        vec_q       <= exc_vec;
        fa_q        <= exc_fault_addr;
        info_q      <= exc_fault_info;
        ir_q        <= exc_ir;
      end else if (step == ST_IDLE && upd_en) begin
        pc_q <= upd_pc;
        sr_q <= upd_sr;
      end
      if (step == ST_LOAD_PC) pc_q <= hnd_q;
      if (acc) begin
        if (step_is_push(step)) ssp_q <= ssp_q - WB_L;
        if (step_is_pop(step))  ssp_q <= ssp_q + WB_L;
        unique case (step)
          ST_RV_SSPH: ssp_q[LW-1:DATA_W] <= mem_rdata;
          ST_RV_SSPL: ssp_q[DATA_W-1:0]  <= mem_rdata;
          ST_RV_PCH:  pc_q[LW-1:DATA_W]  <= mem_rdata;
          ST_RV_PCL:  pc_q[DATA_W-1:0]   <= mem_rdata;
          ST_VEC_H:   hnd_q[LW-1:DATA_W] <= mem_rdata;
          ST_VEC_L:   hnd_q[DATA_W-1:0]  <= mem_rdata;
          ST_POP_SR:  sr_q               <= mem_rdata;
          ST_POP_PCH: pc_q[LW-1:DATA_W]  <= mem_rdata;
          ST_POP_PCL: pc_q[DATA_W-1:0]   <= mem_rdata;
          default: ;
        endcase
      end
    end
  end

  assert_push_supervisor_R2: assert property (@(posedge clk) disable iff (rst)
    step_is_push(step) |-> (sr_q[S_BIT] && !sr_q[T_BIT]));

  assert_push_moves_down_R4: assert property (@(posedge clk) disable iff (rst)
    (acc && step_is_push(step)) |=> ssp_q == $past(ssp_q) - WB_L);

endmodule

// File: rtl/exc_seq_memport.sv
module exc_seq_memport #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              want,
  input  logic [ADDR_W-1:0] addr_c,
  input  logic              we_c,
  input  logic [DATA_W-1:0] wdata_c,
  input  logic              mem_rdy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              acc
);

  assign acc = mem_req && mem_rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (acc) begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
    end else if (!mem_req && want) begin
      mem_req   <= 1'b1;
      mem_we    <= we_c;
      mem_addr  <= addr_c;
      mem_wdata <= wdata_c;
    end
  end

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));

endmodule

// File: rtl/exc_seq_top.sv
module exc_seq_top
  import exc_seq_pkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int          ADDR_W   = 24,
  parameter int          VEC_W    = 8,
  parameter int          GRP_W    = 2,
  parameter int          SEV_GRP  = 0,
  parameter int          S_BIT    = 13,
  parameter int          T_BIT    = 15,
  parameter logic [15:0] RESET_SR = 16'h2700
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                exc_req,
  input  logic [GRP_W-1:0]    exc_grp,
  input  logic [VEC_W-1:0]    exc_vec,
  input  logic [2*DATA_W-1:0] exc_fault_addr,
  input  logic [DATA_W-1:0]   exc_fault_info,
  input  logic [DATA_W-1:0]   exc_ir,
  input  logic                ret_req,
  input  logic                upd_en,
  input  logic [2*DATA_W-1:0] upd_pc,
  input  logic [DATA_W-1:0]   upd_sr,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                mem_rdy,
  output logic [2*DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0]   sr_o,
  output logic [2*DATA_W-1:0] ssp_o,
  output logic                busy,
  output logic                done,
  output logic                priv_err
);

  step_e             step;
  logic              acc;
  logic              start_exc;
  logic              exc_sev;
  logic [ADDR_W-1:0] addr_c;
  logic              we_c;
  logic [DATA_W-1:0] wdata_c;

  assign exc_sev = (exc_grp == GRP_W'(SEV_GRP));

  exc_seq_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .exc_req   (exc_req),
    .exc_sev   (exc_sev),
    .ret_req   (ret_req),
    .s_bit     (sr_o[S_BIT]),
    .acc       (acc),
    .step      (step),
    .start_exc (start_exc),
    .busy      (busy),
    .done      (done),
    .priv_err  (priv_err)
  );

  exc_seq_dp #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .VEC_W    (VEC_W),
    .S_BIT    (S_BIT),
    .T_BIT    (T_BIT),
    .RESET_SR (RESET_SR)
  ) u_dp (
    .clk            (clk),
    .rst            (rst),
    .step           (step),
    .acc            (acc),
    .start_exc      (start_exc),
    .exc_vec        (exc_vec),
    .exc_fault_addr (exc_fault_addr),
    .exc_fault_info (exc_fault_info),
    .exc_ir         (exc_ir),
    .upd_en         (upd_en),
    .upd_pc         (upd_pc),
    .upd_sr         (upd_sr),
    .mem_rdata      (mem_rdata),
    .addr_c         (addr_c),
    .we_c           (we_c),
    .wdata_c        (wdata_c),
    .pc_q           (pc_o),
    .sr_q           (sr_o),
    .ssp_q          (ssp_o)
  );

  exc_seq_memport #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_mem (
    .clk       (clk),
    .rst       (rst),
    .want      (step_is_mem(step)),
    .addr_c    (addr_c),
    .we_c      (we_c),
    .wdata_c   (wdata_c),
    .mem_rdy   (mem_rdy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .acc       (acc)
  );

  assert_access_in_seq_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  assert_write_supervisor_R2: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> sr_o[S_BIT]);

  assert_priv_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    priv_err |-> (!busy && !mem_req));

endmodule

// File: tb/test_exc_seq_top.sv
module test_exc_seq_top;

  localparam int AW = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exc_req = 1'b0;
  logic [1:0]  exc_grp = '0;
  logic [7:0]  exc_vec = '0;
  logic [31:0] exc_fault_addr = '0;
  logic [15:0] exc_fault_info = '0;
  logic [15:0] exc_ir = '0;
  logic        ret_req = 1'b0;
  logic        upd_en = 1'b0;
  logic [31:0] upd_pc = '0;
  logic [15:0] upd_sr = '0;
  logic        mem_req, mem_we, mem_rdy;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [31:0] pc_o, ssp_o;
  logic [15:0] sr_o;
  logic        busy, done, priv_err;

  logic [15:0] mem [0:2047];
  int lat = 0;
  int wcnt = 0;
  int acc_cnt = 0;
  logic [AW-1:0] log_addr [0:31];
  logic          log_we   [0:31];
  int n_chk = 0;
  int n_bad = 0;
  int r8_bad = 0;
  logic   prev_pend = 1'b0;
  logic [AW-1:0] prev_addr;
  logic   prev_we;
  logic [15:0] prev_wd;

  always #2.5 clk = ~clk;

  exc_seq_top #(.ADDR_W(AW)) i_exc_seq_top (
    .clk(clk), .rst(rst), .exc_req(exc_req), .exc_grp(exc_grp),
    .exc_vec(exc_vec), .exc_fault_addr(exc_fault_addr),
    .exc_fault_info(exc_fault_info), .exc_ir(exc_ir), .ret_req(ret_req),
    .upd_en(upd_en), .upd_pc(upd_pc), .upd_sr(upd_sr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
    .pc_o(pc_o), .sr_o(sr_o), .ssp_o(ssp_o),
    .busy(busy), .done(done), .priv_err(priv_err)
  );

  assign mem_rdy   = mem_req && (wcnt >= lat);
  assign mem_rdata = mem[mem_addr[AW-1:1]];

  always @(posedge clk) begin
    if (rst || !mem_req || mem_rdy) wcnt <= 0;
    else wcnt <= wcnt + 1;
    if (!rst && mem_req && mem_rdy) begin
      if (mem_we) mem[mem_addr[AW-1:1]] <= mem_wdata;
      log_addr[acc_cnt % 32] <= mem_addr;
      log_we[acc_cnt % 32]   <= mem_we;
      acc_cnt <= acc_cnt + 1;
    end
  end

  // R8: a pending request must not change before ready
  always @(negedge clk) begin
    if (!rst && prev_pend &&
        (!mem_req || mem_addr !== prev_addr || mem_we !== prev_we ||
         mem_wdata !== prev_wd))
      r8_bad = r8_bad + 1;
    prev_pend = !rst && mem_req && !mem_rdy;
    prev_addr = mem_addr;
    prev_we   = mem_we;
    prev_wd   = mem_wdata;
  end

  task automatic check(input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wait_done(input string rq);
    int c = 0;
    while (done !== 1'b1 && c < 2000) begin
      @(negedge clk);
      c++;
    end
    if (c >= 2000) begin
      n_chk++;
      n_bad++;
      $display("FAIL %s: actual no done expected done", rq);
    end
  endtask

  function automatic logic [31:0] rd32(input logic [31:0] a);
    return {mem[a[AW-1:1]], mem[(a[AW-1:1] + 1) % 2048]};
  endfunction

  task automatic do_reset_check(input string rq);
    int a0;
    a0 = acc_cnt;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({rq, " busy after release"}, busy, 1);
    wait_done(rq);
    check({rq, " sr"}, sr_o, 32'h2700);
    check({rq, " ssp"}, ssp_o, rd32(0));
    check({rq, " pc"}, pc_o, rd32(4));
    check({rq, " reads"}, acc_cnt - a0, 4);
    for (int k = 0; k < 4; k++)
      check({rq, " addr"}, {log_we[(a0 + k) % 32], 20'h0, log_addr[(a0 + k) % 32]},
            32'(2 * k));
  endtask

  task automatic set_core(input logic [31:0] pcv, input logic [15:0] srv);
    upd_en = 1'b1; upd_pc = pcv; upd_sr = srv;
    @(negedge clk);
    upd_en = 1'b0;
  endtask

  task automatic entry(input int v, input logic [1:0] g, input logic both);
    logic [31:0] s0, pcv, hnd, fa;
    logic [15:0] srv, esr, ir, info;
    int a0, nw;
    pcv  = {16'h3000 | 16'(v), 16'(v * 257) ^ 16'h5A5A};
    srv  = 16'(v * 681 + 3) | 16'h2000;
    esr  = (srv | 16'h2000) & 16'h7FFF;
    fa   = {16'(v * 13), 16'(~v)};
    ir   = 16'(v * 7 + 1);
    info = 16'(v) ^ 16'hC3C3;
    set_core(pcv, srv);
    check("R12 idle update pc", pc_o, pcv);
    s0  = ssp_o;
    hnd = rd32(32'(v * 4));
    a0  = acc_cnt;
    exc_req = 1'b1; exc_grp = g; exc_vec = 8'(v);
    exc_fault_addr = fa; exc_fault_info = info; exc_ir = ir;
    ret_req = both;
    @(negedge clk);
    exc_req = 1'b0; ret_req = 1'b0;
    check("R9 busy after accept", busy, 1);
    check("R2 s set t clear", sr_o, esr);
    if (v % 16 == 5) begin
      upd_en = 1'b1; upd_pc = 32'hDEAD_BEEF; upd_sr = 16'h0000;
      @(negedge clk);
      upd_en = 1'b0;
    end
    wait_done("R9 entry done");
    nw = (g == 2'd0) ? 7 : 3;
    check("R3 pc = handler", pc_o, hnd);
    check("R9 busy low at done", busy, 0);
    check("R3 vec hi addr", {log_we[a0 % 32], 20'h0, log_addr[a0 % 32]}, 32'(v * 4));
    check("R3 vec lo addr", {log_we[(a0 + 1) % 32], 20'h0, log_addr[(a0 + 1) % 32]},
          32'(v * 4 + 2));
    check("R2 sr after entry", sr_o, esr);
    check("R4 R5 accesses", acc_cnt - a0, 2 + nw);
    check("R4 R5 ssp", ssp_o, s0 - 32'(2 * nw));
    check("R4 pc hi", mem[(s0 - 4) >> 1], pcv[31:16]);
    check("R4 pc lo", mem[(s0 - 2) >> 1], pcv[15:0]);
    check("R2 stacked sr", mem[(s0 - 6) >> 1], srv);
    if (g == 2'd0) begin
      check("R5 ir", mem[(s0 - 8) >> 1], ir);
      check("R5 fault lo", mem[(s0 - 10) >> 1], fa[15:0]);
      check("R5 fault hi", mem[(s0 - 12) >> 1], fa[31:16]);
      check("R5 info", mem[(s0 - 14) >> 1], info);
    end
    @(negedge clk);
    check("R9 done one cycle", done, 0);
    if (g != 2'd0 && !both) begin
      a0 = acc_cnt;
      ret_req = 1'b1;
      @(negedge clk);
      ret_req = 1'b0;
      wait_done("R6 return done");
      check("R6 pc restored", pc_o, pcv);
      check("R6 sr restored", sr_o, srv);
      check("R6 ssp restored", ssp_o, s0);
      check("R6 reads", acc_cnt - a0, 3);
      check("R6 pop order", {log_addr[a0 % 32], log_addr[(a0 + 1) % 32],
            log_addr[(a0 + 2) % 32]},
            {(AW'(s0) - AW'(6)), (AW'(s0) - AW'(4)), (AW'(s0) - AW'(2))});
      @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 16'(i * 37 + 16'h0100);
    mem[0] = 16'h0000; mem[1] = 16'h0E00;
    mem[2] = 16'h0000; mem[3] = 16'h0400;
    repeat (3) begin
      @(negedge clk);
      check("R1 sr during reset", sr_o, 32'h2700);
      check("R1 no access in reset", mem_req, 0);
    end
    do_reset_check("R1");
    @(negedge clk);

    for (int v = 0; v < 256; v++) begin
      lat = v % 4;
      entry(v, 2'(v % 3), 1'b0);
    end

    // R7: return outside supervisor mode
    begin
      int a0;
      logic [31:0] s0;
      lat = 1;
      set_core(32'h0000_1111, 16'h0005);
      s0 = ssp_o;
      a0 = acc_cnt;
      ret_req = 1'b1;
      @(negedge clk);
      ret_req = 1'b0;
      check("R7 priv_err raised", priv_err, 1);
      check("R7 not busy", busy, 0);
      @(negedge clk);
      check("R7 priv_err one cycle", priv_err, 0);
      repeat (4) @(negedge clk);
      check("R7 no access", acc_cnt - a0, 0);
      check("R7 pc kept", pc_o, 32'h0000_1111);
      check("R7 sr kept", sr_o, 32'h0005);
      check("R7 ssp kept", ssp_o, s0);
    end

    // R11: both requests together, entry wins
    lat = 2;
    entry(77, 2'd1, 1'b1);

    // R10: reset in the middle of an entry
    lat = 3;
    set_core(32'h0000_2222, 16'h2000);
    exc_req = 1'b1; exc_grp = 2'd0; exc_vec = 8'd40;
    @(negedge clk);
    exc_req = 1'b0;
    repeat (9) @(negedge clk);
    check("R10 still busy", busy, 1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 sr reset", sr_o, 32'h2700);
    do_reset_check("R10");

    n_chk++;
    if (r8_bad != 0) begin
      n_bad++;
      $display("FAIL R8: actual %0d changes expected 0", r8_bad);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule